// File: doc/BRIEF.md
# GPIO Bank Register Interface

This block is the software-visible register file for one bank of general-purpose pins, up to 32 lines wide. A simple 32-bit register bus reaches it through a select strobe, a write flag, a byte address and write data. Each line has its own configuration bits: general I/O or interrupt input, direction, output level, output data source, trigger polarity, edge or level sensing, one or both edges, and input enable. From these bits the block drives the pad output-enable and output-data buses. It also passes a synchronised copy of the pad inputs to software and to a separate interrupt sense block.

The interrupt sense block lives elsewhere. This block reads back the sense block's pending status and turns writes at the clear offset into single-cycle clear pulses. It also holds the per-line interrupt enables. Those enables have two write ports. A write at the mask offset can only drop enables. A write at the unmask offset can only raise them. Software can therefore change one line with a single store, with no read-modify-write.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every configuration bit and interrupt enable is 0. pad_oe and pad_out are all 0, and every readable offset returns 0 until something else changes it.
- R2: A read (bus_sel=1, bus_wr=0) loads bus_rdata on the clock edge that samples the strobe. bus_rdata keeps that value through idle cycles and writes until the next read.
- R3: Offset 0x04 holds direction (1 = output) and offset 0x00 holds mode (1 = interrupt input, 0 = general I/O). pad_oe for a line is 1 only when its direction bit is 1 and its mode bit is 0.
- R4: Offset 0x08 holds output data and offset 0x40 holds the source select. A select bit of 0 drives pad_out from the 0x08 bit. A select bit of 1 drives pad_out from alt_out_data.
- R5: Offset 0x0C returns pad_in after a two-flop synchroniser, for outputs as well as inputs. Offset 0x50 enables input per line, and a line with enable 0 reads 0 there and on line_sync.
- R6: Offset 0x10 returns irq_status. A write at 0x14 pulses irq_clr with the written line bits for exactly the cycle after the write. 0x14 reads 0.
- R7: A write at 0x18 clears each interrupt enable whose data bit is 0 and leaves enables whose data bit is 1 unchanged. 0x18 reads the enables, also seen on irq_en. Enables change only on writes at 0x18 or 0x1C.
- R8: A write at 0x1C sets each interrupt enable whose data bit is 1 and leaves the others unchanged. 0x1C reads 0.
- R9: Offsets 0x20 (polarity), 0x24 (edge/level) and 0x4C (both edges) are read/write per line. They are exported on int_pol, int_edge and int_both, and mode is exported on int_mode.
- R10: Any offset not listed above, 0x28 included, reads 0, and writes to it change no register.
- R11: Data bits at or above NUM_LINES read 0 and have no effect when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_LINES | Raw pad input levels |
| alt_out_data | input | NUM_LINES | Alternate output data source |
| irq_status | input | NUM_LINES | Pending status from the sense block |
| pad_oe | output | NUM_LINES | Pad output enable |
| pad_out | output | NUM_LINES | Pad output data |
| line_sync | output | NUM_LINES | Synchronised, enable-gated pad input |
| int_mode | output | NUM_LINES | Line is in interrupt-input mode |
| int_pol | output | NUM_LINES | Polarity select to the sense block |
| int_edge | output | NUM_LINES | Edge (1) or level (0) select |
| int_both | output | NUM_LINES | Both-edge select |
| irq_en | output | NUM_LINES | Interrupt enables |
| irq_clr | output | NUM_LINES | One-cycle interrupt clear pulses |

## Verification
The bench builds the block with NUM_LINES set to 20 rather than the full 32. Write data with bits 20 to 31 set then shows that those bits are dropped on write and read back as zero. With 20 lines, a full-width store also differs from a line-masked readback, so the table of write/readback vectors checks data truncation as well as storage. At 32 lines the same vectors would read back unchanged.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OUT    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IN     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ICLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EDGE   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_OSEL   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_INEN   = 8'h50;

  typedef enum logic [3:0] {
    SEL_MODE   = 4'd0,
    SEL_DIR    = 4'd1,
    SEL_OUT    = 4'd2,
    SEL_POL    = 4'd3,
    SEL_EDGE   = 4'd4,
    SEL_OSEL   = 4'd5,
    SEL_BOTH   = 4'd6,
    SEL_INEN   = 4'd7,
    SEL_IN     = 4'd8,
    SEL_STAT   = 4'd9,
    SEL_ICLR   = 4'd10,
    SEL_MASK   = 4'd11,
    SEL_UNMASK = 4'd12,
    SEL_NONE   = 4'd13
  } reg_sel_e;

  localparam int NUM_SEL   = 14;
  localparam int NUM_PLAIN = 8;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_MODE:   s = SEL_MODE;
      OFS_DIR:    s = SEL_DIR;
      OFS_OUT:    s = SEL_OUT;
      OFS_IN:     s = SEL_IN;
      OFS_STAT:   s = SEL_STAT;
      OFS_ICLR:   s = SEL_ICLR;
      OFS_MASK:   s = SEL_MASK;
      OFS_UNMASK: s = SEL_UNMASK;
      OFS_POL:    s = SEL_POL;
      OFS_EDGE:   s = SEL_EDGE;
      OFS_OSEL:   s = SEL_OSEL;
      OFS_BOTH:   s = SEL_BOTH;
      OFS_INEN:   s = SEL_INEN;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
(
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  output reg_sel_e            rsel,
  output logic [NUM_SEL-1:0]  wr_hit,
  output logic                rd_en
);

  always_comb begin
    rsel   = decode_offset(bus_addr);
    wr_hit = '0;
    if (bus_sel && bus_wr && (rsel != SEL_NONE)) begin
      wr_hit[rsel] = 1'b1;
    end
    rd_en = bus_sel && !bus_wr;
  end

endmodule

// File: rtl/gpio_line_reg.sv
module gpio_line_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/gpio_enable_reg.sv
module gpio_enable_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_we,
  input  logic             raise_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] en
);

  logic [WIDTH-1:0] en_nxt;

  always_comb begin
    en_nxt = en;
    if (drop_we)  en_nxt = en_nxt & wdata;
    if (raise_we) en_nxt = en_nxt | wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= en_nxt;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] en,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q   [STAGES];
  logic [WIDTH-1:0] stage_nxt [STAGES];

  always_comb begin
    stage_nxt[0] = d & en;
    for (int i = 1; i < STAGES; i++) begin
      stage_nxt[i] = stage_q[i-1] & en;
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_nxt[g];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  input  logic [NUM_LINES-1:0] alt_out_data,
  input  logic [NUM_LINES-1:0] irq_status,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] line_sync,
  output logic [NUM_LINES-1:0] int_mode,
  output logic [NUM_LINES-1:0] int_pol,
  output logic [NUM_LINES-1:0] int_edge,
  output logic [NUM_LINES-1:0] int_both,
  output logic [NUM_LINES-1:0] irq_en,
  output logic [NUM_LINES-1:0] irq_clr
);

  localparam int LW = (NUM_LINES < 1) ? 1 : ((NUM_LINES > DATA_W) ? DATA_W : NUM_LINES);
  localparam int SYNC_STAGES = 2;

  reg_sel_e            rsel;
  logic [NUM_SEL-1:0]  wr_hit;
  logic                rd_en;
  logic [LW-1:0]       wline;

  assign wline = bus_wdata[LW-1:0];

  gpio_addr_decode u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .rsel    (rsel),
    .wr_hit  (wr_hit),
    .rd_en   (rd_en)
  );

  // plain read/write line registers, indexed by their decode select
  logic [LW-1:0] plain_q [NUM_PLAIN];

  generate
    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
      gpio_line_reg #(.WIDTH(LW)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_hit[g]),
        .wdata(wline),
        .q    (plain_q[g])
      );
    end
  endgenerate

  logic [LW-1:0] mode_q, dir_q, out_q, pol_q, edge_q, osel_q, both_q, inen_q;

  assign mode_q = plain_q[SEL_MODE];
  assign dir_q  = plain_q[SEL_DIR];
  assign out_q  = plain_q[SEL_OUT];
  assign pol_q  = plain_q[SEL_POL];
  assign edge_q = plain_q[SEL_EDGE];
  assign osel_q = plain_q[SEL_OSEL];
  assign both_q = plain_q[SEL_BOTH];
  assign inen_q = plain_q[SEL_INEN];

  logic [LW-1:0] en_q;

  gpio_enable_reg #(.WIDTH(LW)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .drop_we (wr_hit[SEL_MASK]),
    .raise_we(wr_hit[SEL_UNMASK]),
    .wdata   (wline),
    .en      (en_q)
  );

  logic [LW-1:0] sync_q;

  gpio_in_sync #(.WIDTH(LW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .en   (inen_q),
    .q    (sync_q)
  );

  // clear pulses: next-state and register
  logic [LW-1:0] clr_q, clr_nxt;

  always_comb begin
    clr_nxt = '0;
    if (wr_hit[SEL_ICLR]) clr_nxt = wline;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= '0;
    else        clr_q <= clr_nxt;
  end

  // read mux and registered read data
  logic [LW-1:0]     rd_line;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q, rdata_nxt;

  always_comb begin
    rd_line = '0;
    case (rsel)
      SEL_MODE: rd_line = mode_q;
      SEL_DIR:  rd_line = dir_q;
      SEL_OUT:  rd_line = out_q;
      SEL_POL:  rd_line = pol_q;
      SEL_EDGE: rd_line = edge_q;
      SEL_OSEL: rd_line = osel_q;
      SEL_BOTH: rd_line = both_q;
      SEL_INEN: rd_line = inen_q;
      SEL_IN:   rd_line = sync_q;
      SEL_STAT: rd_line = irq_status;
      SEL_MASK: rd_line = en_q;
      default:  rd_line = '0;
    endcase
    rd_word = '0;
    rd_word[LW-1:0] = rd_line;
  end

  always_comb begin
    rdata_nxt = rdata_q;
    if (rd_en) rdata_nxt = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign bus_rdata = rdata_q;

  // pad and sense-side outputs
  assign pad_oe    = dir_q & ~mode_q;
  assign pad_out   = (out_q & ~osel_q) | (alt_out_data & osel_q);
  assign line_sync = sync_q;
  assign int_mode  = mode_q;
  assign int_pol   = pol_q;
  assign int_edge  = edge_q;
  assign int_both  = both_q;
  assign irq_en    = en_q;
  assign irq_clr   = clr_q;

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [7:0]           bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] pad_oe,
  input logic [NUM_LINES-1:0] int_mode,
  input logic [NUM_LINES-1:0] irq_en,
  input logic [NUM_LINES-1:0] irq_clr
);

  logic wr_mask, wr_unmask, wr_clr, rd_any;

  assign wr_mask   = bus_sel && bus_wr && (bus_addr == OFS_MASK);
  assign wr_unmask = bus_sel && bus_wr && (bus_addr == OFS_UNMASK);
  assign wr_clr    = bus_sel && bus_wr && (bus_addr == OFS_ICLR);
  assign rd_any    = bus_sel && !bus_wr;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(bus_rdata)); // R2

  AST_NO_OE_IN_INT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & int_mode) == '0); // R3

  AST_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_clr) |-> $past(wr_clr)); // R6

  AST_CLR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> irq_clr == $past(bus_wdata[NUM_LINES-1:0])); // R6

  AST_MASK_ONLY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !wr_unmask) |=> (irq_en & ~$past(irq_en)) == '0); // R7

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mask && !wr_unmask) |=> $stable(irq_en)); // R7

  AST_UNMASK_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ($past(irq_en) & ~irq_en) == '0); // R8

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pad_oe   (pad_oe),
  .int_mode (int_mode),
  .irq_en   (irq_en),
  .irq_clr  (irq_clr)
);

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;

  localparam int NL = 20;

  logic          clk;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_wr;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pad_in;
  logic [NL-1:0] alt_out_data;
  logic [NL-1:0] irq_status;
  logic [NL-1:0] pad_oe;
  logic [NL-1:0] pad_out;
  logic [NL-1:0] line_sync;
  logic [NL-1:0] int_mode;
  logic [NL-1:0] int_pol;
  logic [NL-1:0] int_edge;
  logic [NL-1:0] int_both;
  logic [NL-1:0] irq_en;
  logic [NL-1:0] irq_clr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  gpio_bank_regs #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .alt_out_data(alt_out_data), .irq_status(irq_status),
    .pad_oe(pad_oe), .pad_out(pad_out), .line_sync(line_sync),
    .int_mode(int_mode), .int_pol(int_pol), .int_edge(int_edge),
    .int_both(int_both), .irq_en(irq_en), .irq_clr(irq_clr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {offset, write data, expected readback} for NUM_LINES = 20
  localparam logic [71:0] VEC_TBL [8] = '{
    {8'h04, 32'hA5A5A5A5, 32'h0005A5A5},
    {8'h08, 32'h12345678, 32'h00045678},
    {8'h20, 32'hFFFFFFFF, 32'h000FFFFF},
    {8'h24, 32'h0F0F0F0F, 32'h000F0F0F},
    {8'h4C, 32'h3C3C3C3C, 32'h000C3C3C},
    {8'h40, 32'h00000000, 32'h00000000},
    {8'h28, 32'hFFFFFFFF, 32'h00000000},
    {8'h3C, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; alt_out_data = '0; irq_status = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 pad_out", 32'(pad_out), 32'h0);
    chk("R1 irq_en", 32'(irq_en), 32'h0);
    bus_read(8'h00, rd); chk("R1 mode read", rd, 32'h0);
    bus_read(8'h04, rd); chk("R1 dir read", rd, 32'h0);
    bus_read(8'h18, rd); chk("R1 enable read", rd, 32'h0);
    bus_read(8'h50, rd); chk("R1 inen read", rd, 32'h0);

    // R9 R10 R11: write/readback vectors
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC_TBL[i][71:64], VEC_TBL[i][63:32]);
      bus_read(VEC_TBL[i][71:64], rd);
      chk("R9/R10/R11 vector", rd, VEC_TBL[i][31:0]);
    end
    chk("R9 int_pol", 32'(int_pol), 32'h000FFFFF);
    chk("R9 int_edge", 32'(int_edge), 32'h000F0F0F);
    chk("R9 int_both", 32'(int_both), 32'h000C3C3C);
    // R10: stray writes left output data intact
    bus_read(8'h08, rd); chk("R10 out reg intact", rd, 32'h00045678);
    chk("R10 pad_out intact", 32'(pad_out), 32'h00045678);

    // R3: direction and mode
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, 32'h000000FF);
    chk("R3 oe follows dir", 32'(pad_oe), 32'h000000FF);
    bus_write(8'h00, 32'h0000000F);
    chk("R3 int mode blocks oe", 32'(pad_oe), 32'h000000F0);
    chk("R9 int_mode", 32'(int_mode), 32'h0000000F);

    // R4: output source select
    bus_write(8'h08, 32'h0000000F);
    alt_out_data = 20'hABCDE;
    bus_write(8'h40, 32'h0);
    chk("R4 general data", 32'(pad_out), 32'h0000000F);
    bus_write(8'h40, 32'h00000003);
    chk("R4 alternate data", 32'(pad_out), 32'h0000000E);

    // R5: synchroniser and input enable
    pad_in = 20'hFFFFF;
    repeat (4) @(negedge clk);
    bus_read(8'h0C, rd); chk("R5 disabled lines", rd, 32'h0);
    chk("R5 line_sync disabled", 32'(line_sync), 32'h0);
    bus_write(8'h50, 32'h00000FFF);
    repeat (4) @(negedge clk);
    bus_read(8'h0C, rd); chk("R5 enabled lines incl outputs", rd, 32'h00000FFF);
    pad_in = 20'h55555;
    @(negedge clk);
    chk("R5 one cycle still old", 32'(line_sync), 32'h00000FFF);
    @(negedge clk);
    chk("R5 two cycles new", 32'(line_sync), 32'h00000555);

    // R2: registered read holds
    bus_read(8'h20, held);
    chk("R2 read value", held, 32'h000FFFFF);
    repeat (3) @(negedge clk);
    chk("R2 hold idle", bus_rdata, held);
    bus_write(8'h20, 32'h0);
    chk("R2 hold over write", bus_rdata, held);

    // R6: status and clear pulse
    irq_status = 20'h12345;
    bus_read(8'h10, rd); chk("R6 status", rd, 32'h00012345);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'hFFF00081;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R6 clear pulse", 32'(irq_clr), 32'h00000081);
    @(negedge clk);
    chk("R6 pulse ends", 32'(irq_clr), 32'h0);
    bus_read(8'h14, rd); chk("R6 clear reads zero", rd, 32'h0);

    // R7 R8: mask and unmask
    bus_write(8'h1C, 32'hFFFFFFFF);
    bus_read(8'h18, rd); chk("R8 unmask all", rd, 32'h000FFFFF);
    bus_write(8'h18, 32'h000FFF0F);
    bus_read(8'h18, rd); chk("R7 drop zeros", rd, 32'h000FFF0F);
    chk("R7 irq_en port", 32'(irq_en), 32'h000FFF0F);
    bus_write(8'h18, 32'hFFFFFFFF);
    bus_read(8'h18, rd); chk("R7 ones leave unchanged", rd, 32'h000FFF0F);
    bus_write(8'h1C, 32'h000000F0);
    bus_read(8'h18, rd); chk("R8 raise ones", rd, 32'h000FFFFF);
    bus_read(8'h1C, rd); chk("R8 unmask reads zero", rd, 32'h0);
    bus_write(8'h18, 32'h0);
    bus_write(8'h1C, 32'h00000300);
    bus_write(8'h1C, 32'h00000003);
    bus_read(8'h18, rd); chk("R8 accumulate", rd, 32'h00000303);
    bus_write(8'h28, 32'h0);
    chk("R7 unrelated write keeps enables", 32'(irq_en), 32'h00000303);

    // R11: upper bits on the enable register
    bus_write(8'h1C, 32'hFFF00000);
    bus_read(8'h18, rd); chk("R11 upper bits no effect", rd, 32'h00000303);

    finish_run();
  end

endmodule